// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block manages a small group of shared pins that serve two roles in turn. While the supply ramps and reset is held, each pin is an input and reads its own configuration strap, a level set on the board by a pull resistor. Once reset is released the block waits a settling interval counted in reference-clock cycles. At the end of that interval it captures the synchronized pin levels into a control register, and one cycle later it turns every pin into an output.

From that point each pin carries its clock when its captured strap bit is high. When the bit is low the pin is driven steadily low rather than left floating. Two of the pins carry reference clocks and three carry bus clocks. The straps are captured once per reset and pin activity after that has no effect. Pad electrics are outside the block: each pin is modelled as a separate output-enable and output-data path, with the pad's input level fed back in.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is high, and from reset release until the output phase begins, every bit of `pad_oe_o` is 0 and every bit of `pad_do_o` is 0.
- R2: With `SETTLE_CYCLES` = S, all `pad_oe_o` bits are still 0 after the S-th rising clock edge with reset low, and all are 1 after edge S+1.
- R3: The strap captured for pin i is the level of `strap_pin_i[i]` passed through a two-flop synchronizer. Bits 0 and 1 are the reference-clock pins and bits 2 to 4 are the bus-clock pins.
- R4: In the output phase, a pin whose captured strap is 0 has `pad_do_o` held at 0 for any clock level, with `pad_oe_o` at 1.
- R5: In the output phase, a pin whose captured strap is 1 has `pad_do_o` equal to its `clk_src_i` bit.
- R6: Straps are captured exactly once per reset. Changes on `strap_pin_i` during the output phase do not alter `pad_do_o`.
- R7: All `pad_oe_o` bits rise together, only in the cycle after the capture, and stay at 1 until reset.
- R8: Asserting reset during the output phase returns all outputs to 0 after the next edge. After release, new straps are captured following a full settling interval.
- R9: The captured value is the pin level sampled at rising edge S-2 after release. A change made before edge S-2 is captured, and a change made after that edge is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that paces synchronizer, settle counter and sequencer |
| rst | input | 1 | Synchronous active-high reset (power not yet good) |
| strap_pin_i | input | NUM_PINS | Levels read back from the shared pads |
| clk_src_i | input | NUM_PINS | Clocks to be driven on each pad in the output phase |
| pad_oe_o | output | NUM_PINS | Per-pad output enable, 1 = driving |
| pad_do_o | output | NUM_PINS | Per-pad output data (gated clock) |

## Verification
Strap patterns covering all-enabled, all-disabled, and a mix split across the reference and bus groups are each paired with complementary clock-level patterns. This separates a pin that follows its clock from one held low and catches bits swapped between groups. Pin changes after capture show that the register is frozen. Pin changes placed on either side of edge S-2 show exactly which sample the synchronizer delivers to the capture. A mid-output reset shows that the whole sequence repeats with fresh straps.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;

    localparam int unsigned DEF_REF_PINS  = 2;
    localparam int unsigned DEF_BUS_PINS  = 3;
    localparam int unsigned DEF_SETTLE    = 16;
    localparam int unsigned DEF_SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_ARM    = 2'd1,
        PH_DRIVE  = 2'd2
    } phase_t;

    typedef struct packed {
        logic capture;
        logic drive;
    } seq_ctl_t;

    function automatic logic gate_bit(input logic drive, input logic en, input logic clk_in);
        return drive & en & clk_in;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2,
    parameter logic        RST_LV = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= {WIDTH{RST_LV}};
        else     stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= {WIDTH{RST_LV}};
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/strap_sequencer.sv
module strap_sequencer
    import strap_latch_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    output seq_ctl_t ctl_o,
    output phase_t   phase_o
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_SAMPLE: begin
                    if (at_last) phase_q <= PH_ARM;
                    else         cnt_q   <= cnt_q + 1'b1;
                end
                PH_ARM:   phase_q <= PH_DRIVE;
                default:  phase_q <= PH_DRIVE;
            endcase
        end
    end

    assign ctl_o.capture = (phase_q == PH_SAMPLE) && at_last;
    assign ctl_o.drive   = (phase_q == PH_DRIVE);
    assign phase_o       = phase_q;

endmodule

// File: rtl/strap_gate.sv
module strap_gate
    import strap_latch_pkg::*;
(
    input  logic drive_i,
    input  logic en_i,
    input  logic clk_src_i,
    output logic oe_o,
    output logic do_o
);

    assign oe_o = drive_i;
    assign do_o = gate_bit(drive_i, en_i, clk_src_i);

endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_latch_pkg::*;
#(
    parameter int unsigned REF_PINS      = DEF_REF_PINS,
    parameter int unsigned BUS_PINS      = DEF_BUS_PINS,
    parameter int unsigned SETTLE_CYCLES = DEF_SETTLE,
    parameter int unsigned SYNC_LEN      = DEF_SYNC_LEN,
    localparam int unsigned NUM_PINS     = REF_PINS + BUS_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] strap_pin_i,
    input  logic [NUM_PINS-1:0] clk_src_i,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_do_o
);

    logic [NUM_PINS-1:0] strap_sync;
    logic [NUM_PINS-1:0] strap_q;
    seq_ctl_t            seq_ctl;
    phase_t              seq_phase;

    strap_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_LEN),
        .RST_LV (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (strap_pin_i),
        .sync_o  (strap_sync)
    );

    strap_sequencer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ctl_o   (seq_ctl),
        .phase_o (seq_phase)
    );

    always_ff @(posedge clk) begin
        if (rst)                  strap_q <= '1;
        else if (seq_ctl.capture) strap_q <= strap_sync;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        strap_gate u_gate (
            .drive_i   (seq_ctl.drive),
            .en_i      (strap_q[p]),
            .clk_src_i (clk_src_i[p]),
            .oe_o      (pad_oe_o[p]),
            .do_o      (pad_do_o[p])
        );
    end

endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk
    import strap_latch_pkg::*;
#(
    parameter int unsigned NUM_PINS      = 5,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_do,
    input logic [NUM_PINS-1:0] strap_q,
    input phase_t              phase
);

    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 4);
    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)              cyc_q <= '0;
        else if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
    end

    AST_QUIET_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst) (pad_oe == '0) |-> (pad_do == '0)); // R1
    AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (rst) $rose(pad_oe[0]) |-> (cyc_q == CW'(SETTLE_CYCLES + 1))); // R2
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst) pad_oe[0] |-> ((pad_do & ~strap_q) == '0)); // R4
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst) pad_oe[0] |-> $stable(strap_q)); // R6
    AST_OE_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst) (pad_oe == '0) || (pad_oe == '1)); // R7
    AST_OE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst) $rose(pad_oe[0]) |-> ($past(phase) == PH_ARM)); // R7
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst) pad_oe[0] |=> pad_oe[0]); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pad_oe == '0)); // R8

endmodule

bind strap_latch_ctrl strap_latch_chk #(
    .NUM_PINS      (NUM_PINS),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pad_oe  (pad_oe_o),
    .pad_do  (pad_do_o),
    .strap_q (strap_q),
    .phase   (seq_phase)
);

// File: tb/tb_strap_latch_ctrl.sv
module tb_strap_latch_ctrl;

    localparam int S = 16;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] strap_pin_i = '1;
    logic [N-1:0] clk_src_i = '0;
    logic [N-1:0] pad_oe_o;
    logic [N-1:0] pad_do_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    strap_latch_ctrl #(.SETTLE_CYCLES(S)) dut (
        .clk         (clk),
        .rst         (rst),
        .strap_pin_i (strap_pin_i),
        .clk_src_i   (clk_src_i),
        .pad_oe_o    (pad_oe_o),
        .pad_do_o    (pad_do_o)
    );

    // {strap[4:0], clock levels[4:0]}
    localparam logic [9:0] VEC [6] = '{
        10'b11111_10101,
        10'b11111_01010,
        10'b00000_11111,
        10'b00011_11111,
        10'b11100_11111,
        10'b10110_01101
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold reset two cycles with straps applied, release at a falling edge
    task automatic start_seq(input logic [N-1:0] straps);
        @(negedge clk);
        rst = 1'b1;
        strap_pin_i = straps;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        clk_src_i = '1;
        edges(3);
        chk("R1 oe in reset", 32'(pad_oe_o), 32'h0);
        chk("R1 do in reset", 32'(pad_do_o), 32'h0);

        // R2 settle timing, R1 quiet before drive
        start_seq(5'b11111);
        clk_src_i = '1;
        edges(S);
        chk("R2 oe low after edge S", 32'(pad_oe_o), 32'h0);
        chk("R1 do low before drive", 32'(pad_do_o), 32'h0);
        edges(1);
        chk("R2 oe high after edge S+1", 32'(pad_oe_o), 32'h1f);

        // R3 R4 R5 vector table
        foreach (VEC[i]) begin
            logic [N-1:0] st;
            logic [N-1:0] sr;
            st = VEC[i][9:5];
            sr = VEC[i][4:0];
            start_seq(st);
            edges(S + 1);
            clk_src_i = sr;
            #1;
            chk("R3/R5 do follows enabled clocks", 32'(pad_do_o), 32'(st & sr));
            chk("R4 oe driving", 32'(pad_oe_o), 32'h1f);
            clk_src_i = ~sr;
            #1;
            chk("R4/R5 do with inverted clocks", 32'(pad_do_o), 32'(st & ~sr));
        end

        // R6 straps frozen after capture
        start_seq(5'b01001);
        edges(S + 1);
        strap_pin_i = 5'b10110;
        clk_src_i = '1;
        edges(6);
        chk("R6 pin change ignored", 32'(pad_do_o), 32'h09);
        chk("R7 oe stays high", 32'(pad_oe_o), 32'h1f);

        // R8 reset in output phase
        @(negedge clk);
        rst = 1'b1;
        strap_pin_i = 5'b00110;
        edges(1);
        chk("R8 oe cleared after reset edge", 32'(pad_oe_o), 32'h0);
        chk("R8 do cleared after reset edge", 32'(pad_do_o), 32'h0);
        edges(1);
        rst = 1'b0;
        edges(S);
        chk("R8 still quiet before new drive", 32'(pad_oe_o), 32'h0);
        edges(1);
        chk("R8 new straps captured", 32'(pad_do_o), 32'h06);

        // R9 change before edge S-2 is captured
        start_seq(5'b11111);
        edges(S - 3);
        strap_pin_i = 5'b00001;
        edges(4);
        chk("R9 early change captured", 32'(pad_do_o), 32'h01);

        // R9 change after edge S-2 is not captured
        start_seq(5'b11111);
        edges(S - 2);
        strap_pin_i = 5'b00001;
        edges(3);
        chk("R9 late change missed", 32'(pad_do_o), 32'h1f);

        done = 1'b1;
        finish_run();
    end

endmodule